// File: doc/BRIEF.md
# Pin Function and GPIO Register Block

This block holds the configuration of a group of pin ports, each with up to 32 pins, behind a simple word-wide read/write bus. Each pin has a 3-bit function selector, an output data latch, a 2-bit drive-strength code and a 2-bit pull code. Each port also has one group configuration word whose low nibble carries an I/O bias code. The block drives output-enable and output-value lines toward the pad ring. It passes every pad input through a two-flop synchronizer so that the data register can return pin levels. Selectors, drive, pull and bias codes are exported unchanged, so that the pad cells and the alternate-function routing outside the block can use them.

Software sees one bank of nine consecutive words per port, at a stride of 0x24 bytes, and a separate row of group words starting at byte 0x300. A selector value of 1 makes a pin a GPIO output. Value 0 makes it a GPIO input, value 7 switches it off, and every other value names an alternate function that this block only stores. Every access takes one cycle. The response arrives, together with a ready pulse, in the cycle after the request.

Top module: `pinmux_gpio_ctrl`

## Requirements
- R1: Port p owns the word addresses p*9 to p*9+8 (byte address p*0x24 + 4*k). Words k=0..3 are the function words: pin n sits in word n/8, at bits (n%8)*4+2 down to (n%8)*4, and is exported on func_sel[(p*PINS+n)*3 +: 3]. The fourth bit of each nibble reads as zero, and a write to one port leaves every other port unchanged.
- R2: A pin's pad_oe bit is 1 exactly when its selector equals 1; pad_out equals the pin's latch bit when pad_oe is 1 and is 0 otherwise.
- R3: Word k=4 of a port is the data word, bit n for pin n. A write loads the latches. A read returns the latch bit for pins whose selector is 1, and the synchronized pad level for every other pin.
- R4: A pad change applied before clock edge e is seen by reads sampled at edge e+2 and later; reads sampled at edges e and e+1 still return the old level.
- R5: Words k=5 and 6 hold the drive codes: pin n at word 5+n/16, bits (n%16)*2+1:(n%16)*2. The codes are exported on drive_code[(p*PINS+n)*2 +: 2] and read back unchanged.
- R6: Words k=7 and 8 hold the pull codes (0 none, 1 up, 2 down), with the same layout as the drive codes starting at word 7. They are exported on pull_code and read back unchanged.
- R7: The group word of port p sits at byte address 0x300 + 4*p. Its low 4 bits store the bias code, which is exported on bias_code[p*4 +: 4]; bits 31:4 read as zero.
- R8: Addresses outside the banks and the group words read as zero, and writes to them change nothing.
- R9: bus_ready is 1 in the cycle after each cycle with bus_sel high, and 0 otherwise. bus_rdata carries the read data in that cycle, and is zero after a write or an idle cycle.
- R10: After reset every selector is 7, and all latch, drive, pull and bias fields are 0. All exported fields and pad outputs change only in the cycle after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access request, one word per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address (byte address bits 11:2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | Completion pulse one cycle after a request |
| pad_in | input | NUM_PORTS*PINS | Asynchronous pad levels, port-major |
| pad_oe | output | NUM_PORTS*PINS | Pad output enables |
| pad_out | output | NUM_PORTS*PINS | Pad output values |
| func_sel | output | NUM_PORTS*PINS*3 | Per-pin function selectors |
| drive_code | output | NUM_PORTS*PINS*2 | Per-pin drive-strength codes |
| pull_code | output | NUM_PORTS*PINS*2 | Per-pin pull codes |
| bias_code | output | NUM_PORTS*4 | Per-port bias codes |

## Verification
A wrong field position or a decoder slip shows up in the next cycle on the exported selector, drive, pull or bias vectors. It shows up again one cycle after any read of the affected word, so sweeping every word of every port with distinct patterns exposes it at once. A wrong pin in the data composite shows up as a mismatched pad_oe bit or data bit in the first read after the selectors are set. An error in the synchronizer depth is caught by three back-to-back reads around a pad change, which tell a one-stage, a two-stage and a three-stage path apart.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
    localparam int BUS_W      = 32;
    localparam int BANK_WORDS = 9;
    localparam int PIDX_W     = 5;
    localparam int SUB_DATA   = 4;
    localparam int SUB_DRIVE  = 5;
    localparam int SUB_PULL   = 7;
    localparam int BIAS_WORD  = 192;

    localparam logic [2:0] SEL_IN  = 3'd0;
    localparam logic [2:0] SEL_OUT = 3'd1;
    localparam logic [2:0] SEL_OFF = 3'd7;

    typedef struct packed {
        logic              bank_hit;
        logic              bias_hit;
        logic [PIDX_W-1:0] port;
        logic [3:0]        sub;
    } pmx_hit_t;
endpackage

// File: rtl/pmx_addr_decode.sv
module pmx_addr_decode
    import pmx_pkg::*;
#(
    parameter int NUM_PORTS = 9
) (
    input  logic [11:2] word_addr,
    output pmx_hit_t    hit
);
    always_comb begin
        int wa;
        wa  = int'({22'd0, word_addr});
        hit = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (wa >= p * BANK_WORDS && wa < (p + 1) * BANK_WORDS) begin
                hit.bank_hit = 1'b1;
                hit.port     = PIDX_W'(p);
                hit.sub      = 4'(wa - p * BANK_WORDS);
            end
            if (wa == BIAS_WORD + p) begin
                hit.bias_hit = 1'b1;
                hit.port     = PIDX_W'(p);
            end
        end
    end
endmodule

// File: rtl/pmx_sync.sv
module pmx_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    typedef struct packed {
        logic [WIDTH-1:0] first;
        logic [WIDTH-1:0] second;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.first  = async_in;
        st_d.second = st_q.first;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.second;
endmodule

// File: rtl/pmx_port_regs.sv
module pmx_port_regs
    import pmx_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_we,
    input  logic              bias_we,
    input  logic [3:0]        sub,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [PINS-1:0]   pad_sync,
    output logic [PINS*3-1:0] sel_o,
    output logic [PINS-1:0]   oe_o,
    output logic [PINS-1:0]   out_o,
    output logic [PINS*2-1:0] drive_o,
    output logic [PINS*2-1:0] pull_o,
    output logic [3:0]        bias_o,
    output logic [BUS_W-1:0]  bank_rd
);
    typedef struct packed {
        logic [PINS-1:0][2:0] sel;
        logic [PINS-1:0]      latch;
        logic [PINS-1:0][1:0] drive;
        logic [PINS-1:0][1:0] pull;
        logic [3:0]           bias;
    } port_st_t;

    port_st_t st_d, st_q;

    always_comb begin
        int k;
        k    = int'(sub);
        st_d = st_q;
        if (bank_we) begin
            for (int n = 0; n < PINS; n++) begin
                if (k == n / 8)             st_d.sel[n]   = wdata[(n % 8) * 4 +: 3];
                if (k == SUB_DATA)          st_d.latch[n] = wdata[n];
                if (k == SUB_DRIVE + n / 16) st_d.drive[n] = wdata[(n % 16) * 2 +: 2];
                if (k == SUB_PULL + n / 16)  st_d.pull[n]  = wdata[(n % 16) * 2 +: 2];
            end
        end
        if (bias_we) st_d.bias = wdata[3:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel   <= {PINS{SEL_OFF}};
            st_q.latch <= '0;
            st_q.drive <= '0;
            st_q.pull  <= '0;
            st_q.bias  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        int k;
        k       = int'(sub);
        bank_rd = '0;
        for (int n = 0; n < PINS; n++) begin
            if (k == n / 8)              bank_rd[(n % 8) * 4 +: 3]  = st_q.sel[n];
            if (k == SUB_DATA)           bank_rd[n] = (st_q.sel[n] == SEL_OUT) ? st_q.latch[n] : pad_sync[n];
            if (k == SUB_DRIVE + n / 16) bank_rd[(n % 16) * 2 +: 2] = st_q.drive[n];
            if (k == SUB_PULL + n / 16)  bank_rd[(n % 16) * 2 +: 2] = st_q.pull[n];
        end
    end

    for (genvar n = 0; n < PINS; n++) begin : g_pin
        assign oe_o[n]           = (st_q.sel[n] == SEL_OUT);
        assign out_o[n]          = oe_o[n] & st_q.latch[n];
        assign sel_o[n*3 +: 3]   = st_q.sel[n];
        assign drive_o[n*2 +: 2] = st_q.drive[n];
        assign pull_o[n*2 +: 2]  = st_q.pull[n];
    end

    assign bias_o = st_q.bias;
endmodule

// File: rtl/pinmux_gpio_ctrl.sv
module pinmux_gpio_ctrl
    import pmx_pkg::*;
#(
    parameter int NUM_PORTS = 9,
    parameter int PINS      = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_sel,
    input  logic                        bus_wr,
    input  logic [11:2]                 bus_addr,
    input  logic [31:0]                 bus_wdata,
    output logic [31:0]                 bus_rdata,
    output logic                        bus_ready,
    input  logic [NUM_PORTS*PINS-1:0]   pad_in,
    output logic [NUM_PORTS*PINS-1:0]   pad_oe,
    output logic [NUM_PORTS*PINS-1:0]   pad_out,
    output logic [NUM_PORTS*PINS*3-1:0] func_sel,
    output logic [NUM_PORTS*PINS*2-1:0] drive_code,
    output logic [NUM_PORTS*PINS*2-1:0] pull_code,
    output logic [NUM_PORTS*4-1:0]      bias_code
);
    localparam int TOTAL = NUM_PORTS * PINS;

    typedef struct packed {
        logic             ready;
        logic [BUS_W-1:0] rdata;
    } bus_st_t;

    pmx_hit_t          hit;
    logic [TOTAL-1:0]  pad_sync;
    logic [BUS_W-1:0]  port_rd [NUM_PORTS];
    logic [BUS_W-1:0]  rd_word;
    bus_st_t           bus_d, bus_q;

    pmx_addr_decode #(.NUM_PORTS(NUM_PORTS)) u_decode (
        .word_addr (bus_addr),
        .hit       (hit)
    );

    pmx_sync #(.WIDTH(TOTAL)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pad_sync)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic mine;
        assign mine = bus_sel & bus_wr & (hit.port == PIDX_W'(p));

        pmx_port_regs #(.PINS(PINS)) u_regs (
            .clk      (clk),
            .rst_n    (rst_n),
            .bank_we  (mine & hit.bank_hit),
            .bias_we  (mine & hit.bias_hit),
            .sub      (hit.sub),
            .wdata    (bus_wdata),
            .pad_sync (pad_sync[p*PINS +: PINS]),
            .sel_o    (func_sel[p*PINS*3 +: PINS*3]),
            .oe_o     (pad_oe[p*PINS +: PINS]),
            .out_o    (pad_out[p*PINS +: PINS]),
            .drive_o  (drive_code[p*PINS*2 +: PINS*2]),
            .pull_o   (pull_code[p*PINS*2 +: PINS*2]),
            .bias_o   (bias_code[p*4 +: 4]),
            .bank_rd  (port_rd[p])
        );
    end

    always_comb begin
        rd_word = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (hit.port == PIDX_W'(p)) begin
                if (hit.bank_hit)      rd_word = port_rd[p];
                else if (hit.bias_hit) rd_word = {28'd0, bias_code[p*4 +: 4]};
            end
        end
    end

    always_comb begin
        bus_d.ready = bus_sel;
        bus_d.rdata = (bus_sel && !bus_wr) ? rd_word : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_q <= '0;
        else        bus_q <= bus_d;
    end

    assign bus_ready = bus_q.ready;
    assign bus_rdata = bus_q.rdata;
endmodule

// File: rtl/pmx_gpio_checker.sv
module pmx_gpio_checker #(
    parameter int NUM_PORTS = 9,
    parameter int PINS      = 32
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bus_sel,
    input logic                        bus_wr,
    input logic [11:2]                 bus_addr,
    input logic [31:0]                 bus_rdata,
    input logic                        bus_ready,
    input logic [NUM_PORTS*PINS-1:0]   pad_oe,
    input logic [NUM_PORTS*PINS-1:0]   pad_out,
    input logic [NUM_PORTS*PINS*3-1:0] func_sel,
    input logic [NUM_PORTS*PINS*2-1:0] drive_code,
    input logic [NUM_PORTS*PINS*2-1:0] pull_code,
    input logic [NUM_PORTS*4-1:0]      bias_code
);
    logic unmapped;

    always_comb begin
        int wa;
        wa       = int'({22'd0, bus_addr});
        unmapped = !(wa < NUM_PORTS * 9) && !(wa >= 192 && wa < 192 + NUM_PORTS);
    end

    assert_ready_after_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel |=> bus_ready);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> (!bus_ready && bus_rdata == 32'd0));

    assert_write_returns_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr) |=> (bus_rdata == 32'd0));

    assert_unmapped_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && unmapped) |=> (bus_rdata == 32'd0));

    assert_unmapped_write_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && unmapped) |=> ($stable(func_sel) && $stable(drive_code) &&
            $stable(pull_code) && $stable(bias_code) && $stable(pad_oe) && $stable(pad_out)));

    assert_hold_without_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr) |=> ($stable(func_sel) && $stable(drive_code) &&
            $stable(pull_code) && $stable(bias_code) && $stable(pad_oe) && $stable(pad_out)));
endmodule

bind pinmux_gpio_ctrl pmx_gpio_checker #(.NUM_PORTS(NUM_PORTS), .PINS(PINS)) u_pmx_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .bus_ready  (bus_ready),
    .pad_oe     (pad_oe),
    .pad_out    (pad_out),
    .func_sel   (func_sel),
    .drive_code (drive_code),
    .pull_code  (pull_code),
    .bias_code  (bias_code)
);

// File: tb/test_pinmux_gpio_ctrl.sv
`timescale 1ns/1ps
module test_pinmux_gpio_ctrl;
    localparam int NP = 9;
    localparam int NPIN = 32;
    localparam int T = NP * NPIN;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_sel = 1'b0;
    logic            bus_wr = 1'b0;
    logic [11:2]     bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            bus_ready;
    logic [T-1:0]    pad_in = '0;
    logic [T-1:0]    pad_oe, pad_out;
    logic [T*3-1:0]  func_sel;
    logic [T*2-1:0]  drive_code, pull_code;
    logic [NP*4-1:0] bias_code;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pinmux_gpio_ctrl #(.NUM_PORTS(NP), .PINS(NPIN)) i_pinmux_gpio_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
        .func_sel(func_sel), .drive_code(drive_code), .pull_code(pull_code),
        .bias_code(bias_code)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a[11:2]; bus_wdata = d;
        @(negedge clk);
        check("R9 write ready", {31'd0, bus_ready}, 32'd1);
        check("R9 write rdata", bus_rdata, 32'd0);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a[11:2];
        @(negedge clk);
        check("R9 read ready", {31'd0, bus_ready}, 32'd1);
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    function automatic logic [11:0] bank_addr(input int p, input int k);
        return 12'(p * 36 + k * 4);
    endfunction

    function automatic logic [31:0] pat(input int p, input int k);
        return (32'(p * 16 + k + 1) * 32'h9E3779B9) ^ 32'hC3A51E07;
    endfunction

    function automatic logic [2:0] selv(input int p, input int n);
        case ((n + p) % 4)
            0: return 3'd1;
            1: return 3'd0;
            2: return 3'd7;
            default: return 3'(2 + n % 5);
        endcase
    endfunction

    function automatic logic [31:0] func_word(input int p, input int k);
        logic [31:0] w = '0;
        for (int j = 0; j < 8; j++) w[j*4 +: 3] = selv(p, k * 8 + j);
        return w;
    endfunction

    function automatic logic [31:0] out_mask(input int p);
        logic [31:0] m = '0;
        for (int n = 0; n < NPIN; n++) m[n] = (selv(p, n) == 3'd1);
        return m;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, e, old_v, new_v;
        logic [T-1:0] s_oe, s_out;
        logic [T*3-1:0] s_sel;
        logic [T*2-1:0] s_drv, s_pul;
        logic [NP*4-1:0] s_bias;
        logic [11:0] bad_addrs [6];

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state at the ports and through reads
        check("R10 ready idle", {31'd0, bus_ready}, 32'd0);
        for (int p = 0; p < NP; p++) begin
            check("R10 oe reset", pad_oe[p*NPIN +: 32], 32'd0);
            check("R10 bias reset", {28'd0, bias_code[p*4 +: 4]}, 32'd0);
            for (int k = 0; k < 9; k++) begin
                bus_read(bank_addr(p, k), r);
                check("R10 bank reset", r, (k < 4) ? 32'h77777777 : 32'd0);
            end
            bus_read(12'(12'h300 + p * 4), r);
            check("R10 group reset", r, 32'd0);
        end
        for (int i = 0; i < T; i++) check("R10 sel reset", {29'd0, func_sel[i*3 +: 3]}, 32'd7);

        // R1 R5 R6 R7: pattern sweep over all configuration words
        for (int p = 0; p < NP; p++) begin
            for (int k = 0; k < 9; k++) if (k != 4) bus_write(bank_addr(p, k), pat(p, k));
            bus_write(12'(12'h300 + p * 4), pat(p, 9));
        end
        for (int p = 0; p < NP; p++) begin
            for (int k = 0; k < 9; k++) begin
                if (k == 4) continue;
                bus_read(bank_addr(p, k), r);
                if (k < 4) check("R1 func readback", r, pat(p, k) & 32'h77777777);
                else if (k < 7) check("R5 drive readback", r, pat(p, k));
                else check("R6 pull readback", r, pat(p, k));
            end
            bus_read(12'(12'h300 + p * 4), r);
            check("R7 group readback", r, {28'd0, pat(p, 9) & 32'hF});
            check("R7 bias export", {28'd0, bias_code[p*4 +: 4]}, {28'd0, pat(p, 9) & 32'hF});
            for (int n = 0; n < NPIN; n++) begin
                e = (pat(p, n / 8) >> ((n % 8) * 4)) & 32'd7;
                check("R1 sel export", {29'd0, func_sel[(p*NPIN+n)*3 +: 3]}, e);
                e = (pat(p, 5 + n / 16) >> ((n % 16) * 2)) & 32'd3;
                check("R5 drive export", {30'd0, drive_code[(p*NPIN+n)*2 +: 2]}, e);
                e = (pat(p, 7 + n / 16) >> ((n % 16) * 2)) & 32'd3;
                check("R6 pull export", {30'd0, pull_code[(p*NPIN+n)*2 +: 2]}, e);
            end
        end

        // R2 R3: mixed selectors, latch and pad composite
        for (int p = 0; p < NP; p++) pad_in[p*NPIN +: 32] = ~pat(p, 11);
        for (int p = 0; p < NP; p++) begin
            for (int k = 0; k < 4; k++) bus_write(bank_addr(p, k), func_word(p, k));
            bus_write(bank_addr(p, 4), pat(p, 4));
        end
        repeat (3) @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            e = (pat(p, 4) & out_mask(p)) | (~pat(p, 11) & ~out_mask(p));
            bus_read(bank_addr(p, 4), r);
            check("R3 data composite", r, e);
            check("R2 oe", pad_oe[p*NPIN +: 32], out_mask(p));
            check("R2 pad out", pad_out[p*NPIN +: 32], pat(p, 4) & out_mask(p));
        end

        // R4: three back-to-back reads around a pad change on port 2
        old_v = (pat(2, 4) & out_mask(2)) | (~pat(2, 11) & ~out_mask(2));
        new_v = (pat(2, 4) & out_mask(2)) | (pat(2, 11) & ~out_mask(2));
        pad_in[2*NPIN +: 32] = pat(2, 11);
        bus_read(bank_addr(2, 4), r); check("R4 edge e old", r, old_v);
        bus_read(bank_addr(2, 4), r); check("R4 edge e+1 old", r, old_v);
        bus_read(bank_addr(2, 4), r); check("R4 edge e+2 new", r, new_v);

        // R8: unmapped writes and reads; R10: idle stability
        bad_addrs[0] = 12'h144; bad_addrs[1] = 12'h148; bad_addrs[2] = 12'h200;
        bad_addrs[3] = 12'h2FC; bad_addrs[4] = 12'h324; bad_addrs[5] = 12'hFFC;
        s_oe = pad_oe; s_out = pad_out; s_sel = func_sel; s_drv = drive_code;
        s_pul = pull_code; s_bias = bias_code;
        for (int i = 0; i < 6; i++) begin
            bus_write(bad_addrs[i], 32'hFFFFFFFF);
            @(negedge clk);
            check("R8 no change sel", {31'd0, func_sel == s_sel}, 32'd1);
            check("R8 no change drv/pull", {31'd0, (drive_code == s_drv) && (pull_code == s_pul)}, 32'd1);
            check("R8 no change pads/bias", {31'd0, (pad_oe == s_oe) && (pad_out == s_out) && (bias_code == s_bias)}, 32'd1);
            bus_read(bad_addrs[i], r);
            check("R8 unmapped read", r, 32'd0);
        end
        repeat (4) @(negedge clk);
        check("R9 idle ready", {31'd0, bus_ready}, 32'd0);
        check("R9 idle rdata", bus_rdata, 32'd0);
        check("R10 idle stable", {31'd0, (func_sel == s_sel) && (pad_oe == s_oe) && (bias_code == s_bias)}, 32'd1);

        // R1: writing port 0 leaves port 1 intact
        bus_write(bank_addr(0, 0), 32'h0);
        bus_read(bank_addr(1, 0), r);
        check("R1 port isolation", r, func_word(1, 0));
        bus_read(bank_addr(0, 0), r);
        check("R1 port 0 updated", r, 32'd0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule